// File: doc/BRIEF.md
# T1 Facility Data Link Byte Buffer

This block sits between a T1 framer's bit-level data-link slots and a processor register port. On the transmit side the host writes a byte into a holding register. Each time the framer opens a data-link bit slot, the block presents one bit of that byte on a serial output, least significant bit first. A new byte is taken from the holding register at every byte boundary, so a byte the host has not rewritten is sent again. In the superframe (D4) mode only six bits of each byte go out.

On the receive side, each recovered data-link bit is collected into a byte, least significant bit first. In D4 mode the block collects the Fs framing bits instead, six per byte, aligned to a multiframe marker from the framer. Bits are delivered raw, with no zero-bit removal. When a byte completes, it is copied to a read register and a sticky full flag is set. If the host has unmasked that flag, an active-low interrupt is driven. The host has one byte time to read the byte before the next one replaces it.

Top module: `t1_fdl_buf`

## Requirements
- R1: After reset the receive register, the full flag and the mask read 0, the transmit holding register reads 0, `tx_bit_o` is 0 and `irq_no` is 1.
- R2: In ESF mode (`d4_mode_i`=0), successive transmit slots carry bits 0 through 7 of the byte, in that order. The output only changes after a slot or a write to the holding register.
- R3: In D4 mode (`d4_mode_i`=1), each transmit byte uses six slots carrying bits 0 through 5. Bits 7:6 are never sent.
- R4: The holding register (address 0, read/write) is sampled in the slot that carries bit 0. A write in the middle of a byte affects only the next byte. With no write, the same byte repeats.
- R5: In ESF mode, eight receive slots fill a byte, with the first bit in bit 0. On the eighth bit the byte appears at address 1 and the full flag (address 2, bit 0) is set.
- R6: In D4 mode, six receive slots fill a byte in bits 5:0. Bits 7:6 of the delivered byte read 0.
- R7: A receive slot with `rx_sync_i`=1 is taken as bit 0 of a new byte, and any partial byte is discarded.
- R8: The full flag clears when the host reads address 2, or writes address 2 with bit 0 set. Writing 0 leaves it set. A byte completing in the same cycle keeps it set.
- R9: `irq_no` is 0 exactly when the full flag is set and the mask (address 3, bit 0) is 1.
- R10: A byte that completes while the previous one is unread replaces it, and the full flag stays set.
- R11: No bits are removed or inserted in either direction. A run of five ones followed by a zero is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| d4_mode_i | input | 1 | 1 = D4 (six-bit bytes, Fs bits), 0 = ESF |
| tx_slot_i | input | 1 | Transmit data-link bit slot strobe |
| tx_bit_o | output | 1 | Bit to insert in the current transmit slot |
| rx_slot_i | input | 1 | Receive bit valid strobe |
| rx_bit_i | input | 1 | Recovered data-link or Fs bit |
| rx_sync_i | input | 1 | Marks the received bit as bit 0 of a byte |
| reg_wr_i | input | 1 | Host write strobe |
| reg_rd_i | input | 1 | Host read strobe (clears status on address 2) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Directed cases send a byte with distinct halves (0xA5) so that bit order and a reversed or stuck bit show up. A write in the middle of a byte tells a snapshot at the byte boundary apart from a live read of the holding register. A byte 0xC7 in D4 mode shows whether bits 7:6 leak out. On receive, a run of five ones followed by a zero would expose any destuffing. A sync pulse after a partial byte tells realignment apart from plain counting. Back-to-back bytes with no read check overwrite. Random streams of slots, host writes, status reads and mask changes in each mode are then compared bit by bit with a bench model.

// File: rtl/t1_fdl_pkg.sv
package t1_fdl_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned D4_W   = 6;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_TXD  = 2'd0,
    A_RXD  = 2'd1,
    A_STAT = 2'd2,
    A_MASK = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/t1_fdl_tx.sv
module t1_fdl_tx #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned D4_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d4_mode_i,
  input  logic              slot_i,
  input  logic [BYTE_W-1:0] hold_i,
  output logic              bit_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last;
  logic [BYTE_W-1:0] sr_q;

  assign last  = d4_mode_i ? CNT_W'(D4_W - 1) : CNT_W'(BYTE_W - 1);
  // bit 0 comes straight from the holding register; the rest from the snapshot
  assign bit_o = (cnt_q == '0) ? hold_i[0] : sr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (slot_i) begin
      cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
      sr_q  <= (cnt_q == '0) ? (hold_i >> 1) : (sr_q >> 1);
    end
  end
endmodule

// File: rtl/t1_fdl_rx.sv
module t1_fdl_rx #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned D4_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d4_mode_i,
  input  logic              slot_i,
  input  logic              bit_i,
  input  logic              sync_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q, pos, last;
  logic [BYTE_W-1:0] acc_q, acc_d, keep;
  logic [BYTE_W-1:0] data_q;

  assign last   = d4_mode_i ? CNT_W'(D4_W - 1) : CNT_W'(BYTE_W - 1);
  assign pos    = sync_i ? '0 : cnt_q;
  assign done_o = slot_i && (pos >= last);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_keep
    assign keep[i] = !d4_mode_i || (i < D4_W);
  end

  always_comb begin
    acc_d      = (pos == '0) ? '0 : acc_q;
    acc_d[pos] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      data_q <= '0;
    end else if (slot_i) begin
      acc_q <= acc_d;
      cnt_q <= done_o ? '0 : pos + 1'b1;
      if (done_o) data_q <= acc_d & keep;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/t1_fdl_regs.sv
module t1_fdl_regs
  import t1_fdl_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rx_done_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic [BYTE_W-1:0] hold_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              full_o,
  output logic              irq_no
);
  logic [BYTE_W-1:0] hold_q;
  logic              full_q, mask_q, clr;

  assign clr = (rd_i && addr_i == A_STAT) || (wr_i && addr_i == A_STAT && wdata_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_TXD)  hold_q <= wdata_i;
      if (wr_i && addr_i == A_MASK) mask_q <= wdata_i[0];
      if (rx_done_i)                full_q <= 1'b1;  // set beats clear
      else if (clr)                 full_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_TXD:   rdata_o = hold_q;
      A_RXD:   rdata_o = rx_data_i;
      A_STAT:  rdata_o = {{(BYTE_W-1){1'b0}}, full_q};
      default: rdata_o = {{(BYTE_W-1){1'b0}}, mask_q};
    endcase
  end

  assign hold_o = hold_q;
  assign full_o = full_q;
  assign irq_no = ~(full_q & mask_q);
endmodule

// File: rtl/t1_fdl_buf.sv
module t1_fdl_buf
  import t1_fdl_pkg::*;
#(
  parameter int unsigned BYTE_W = t1_fdl_pkg::BYTE_W,
  parameter int unsigned D4_W   = t1_fdl_pkg::D4_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d4_mode_i,
  input  logic              tx_slot_i,
  output logic              tx_bit_o,
  input  logic              rx_slot_i,
  input  logic              rx_bit_i,
  input  logic              rx_sync_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              irq_no
);
  logic [BYTE_W-1:0] hold, rx_data;
  logic              rx_done, full;

  t1_fdl_tx #(.BYTE_W(BYTE_W), .D4_W(D4_W)) u_tx (
    .clk_i, .rst_ni, .d4_mode_i,
    .slot_i (tx_slot_i),
    .hold_i (hold),
    .bit_o  (tx_bit_o)
  );

  t1_fdl_rx #(.BYTE_W(BYTE_W), .D4_W(D4_W)) u_rx (
    .clk_i, .rst_ni, .d4_mode_i,
    .slot_i (rx_slot_i),
    .bit_i  (rx_bit_i),
    .sync_i (rx_sync_i),
    .done_o (rx_done),
    .data_o (rx_data)
  );

  t1_fdl_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rx_done_i (rx_done),
    .rx_data_i (rx_data),
    .hold_o    (hold),
    .rdata_o   (reg_rdata_o),
    .full_o    (full),
    .irq_no    (irq_no)
  );
endmodule

// File: rtl/t1_fdl_chk.sv
module t1_fdl_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned D4_W   = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              d4_mode_i,
  input logic              tx_slot_i,
  input logic              tx_bit_o,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [1:0]        reg_addr_i,
  input logic [BYTE_W-1:0] reg_wdata_i,
  input logic              irq_no,
  input logic              rx_done,
  input logic              full,
  input logic [BYTE_W-1:0] rx_data
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (irq_no && !full);
    end
  end

  p_tx_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_slot_i && !(reg_wr_i && reg_addr_i == 2'd0)) |=> $stable(tx_bit_o));

  p_full_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done |=> full);

  p_d4_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && d4_mode_i) |=> (rx_data[BYTE_W-1:D4_W] == '0));

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 2'd2 && !rx_done) |=> !full);

  p_mask_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd3 && !reg_wdata_i[0]) |=> irq_no);

  p_irq_needs_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> full);
endmodule

bind t1_fdl_buf t1_fdl_chk #(.BYTE_W(BYTE_W), .D4_W(D4_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .d4_mode_i   (d4_mode_i),
  .tx_slot_i   (tx_slot_i),
  .tx_bit_o    (tx_bit_o),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_no      (irq_no),
  .rx_done     (rx_done),
  .full        (full),
  .rx_data     (rx_data)
);

// File: tb/sim_t1_fdl_buf.sv
module sim_t1_fdl_buf;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       d4 = 1'b0, tx_slot = 1'b0, rx_slot = 1'b0, rx_bit = 1'b0, rx_sync = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       tx_bit, irq_n;
  logic [7:0] rdata;

  int tests = 0, fails = 0;

  // bench model
  logic [7:0] m_hold, m_snap, m_acc, m_rx;
  int         m_tcnt, m_rcnt;
  logic       m_full, m_mask;

  always #2 clk = ~clk;

  t1_fdl_buf u0 (
    .clk_i(clk), .rst_ni(rst_ni), .d4_mode_i(d4),
    .tx_slot_i(tx_slot), .tx_bit_o(tx_bit),
    .rx_slot_i(rx_slot), .rx_bit_i(rx_bit), .rx_sync_i(rx_sync),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_no(irq_n)
  );

  function automatic int last_idx();
    return d4 ? 5 : 7;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; tx_slot = 1'b0; rx_slot = 1'b0; rx_sync = 1'b0;
  endtask

  task automatic chk_irq(input string req);
    chk(req, int'(irq_n), int'(!(m_full && m_mask)));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step();
    step();
    rst_ni = 1'b1;
    m_hold = 0; m_snap = 0; m_acc = 0; m_rx = 0;
    m_tcnt = 0; m_rcnt = 0; m_full = 0; m_mask = 0;
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    if (a == 2'd0) m_hold = d;
    if (a == 2'd3) m_mask = d[0];
    if (a == 2'd2 && d[0]) m_full = 1'b0;
    chk_irq("R9 irq after write");
  endtask

  task automatic host_rd(input string req, input logic [1:0] a);
    logic [7:0] exp;
    rd = 1'b1; addr = a;
    case (a)
      2'd0: exp = m_hold;
      2'd1: exp = m_rx;
      2'd2: exp = {7'd0, m_full};
      default: exp = {7'd0, m_mask};
    endcase
    #1;
    chk(req, int'(rdata), int'(exp));
    step();
    if (a == 2'd2) m_full = 1'b0;
    chk_irq("R8 irq after read");
  endtask

  task automatic send_slot(input string req);
    logic exp;
    exp = (m_tcnt == 0) ? m_hold[0] : m_snap[m_tcnt];
    chk(req, int'(tx_bit), int'(exp));
    if (m_tcnt == 0) m_snap = m_hold;
    m_tcnt = (m_tcnt >= last_idx()) ? 0 : m_tcnt + 1;
    tx_slot = 1'b1;
    step();
  endtask

  task automatic recv_slot(input logic b, input logic s);
    int pos;
    rx_slot = 1'b1; rx_bit = b; rx_sync = s;
    step();
    pos = s ? 0 : m_rcnt;
    if (pos == 0) m_acc = 8'd0;
    m_acc[pos] = b;
    if (pos >= last_idx()) begin
      m_rx = d4 ? (m_acc & 8'h3f) : m_acc;
      m_full = 1'b1;
      m_rcnt = 0;
    end else m_rcnt = pos + 1;
    chk_irq("R9 irq after receive");
  endtask

  task automatic recv_byte(input logic [7:0] v, input logic first_sync);
    for (int i = 0; i <= last_idx(); i++) recv_slot(v[i], first_sync && i == 0);
  endtask

  task automatic random_phase(input logic mode, input int n);
    do_reset();
    d4 = mode;
    for (int i = 0; i < n; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: send_slot(mode ? "R3 random tx" : "R2 random tx");
        3, 4, 5: recv_slot(1'($urandom_range(0, 1)), $urandom_range(0, 15) == 0);
        6: host_wr(2'd0, 8'($urandom_range(0, 255)));
        7: host_rd("R5 random rx data", 2'd1);
        8: if ($urandom_range(0, 1) == 1) host_rd("R8 random status", 2'd2);
           else host_wr(2'd2, 8'($urandom_range(0, 1)));
        default: host_wr(2'd3, 8'($urandom_range(0, 1)));
      endcase
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 tx_bit", int'(tx_bit), 0);
    chk("R1 irq", int'(irq_n), 1);
    host_rd("R1 hold", 2'd0);
    host_rd("R1 rx data", 2'd1);
    host_rd("R1 status", 2'd2);
    host_rd("R1 mask", 2'd3);

    // R2/R4 ESF transmit and repeat
    host_wr(2'd0, 8'hA5);
    for (int i = 0; i < 16; i++) send_slot("R2 ESF tx bit");
    // R4 mid-byte write only affects next byte
    for (int i = 0; i < 3; i++) send_slot("R4 tx before write");
    host_wr(2'd0, 8'h3C);
    for (int i = 0; i < 13; i++) send_slot("R4 tx after write");

    // R3 D4 transmit
    do_reset();
    d4 = 1'b1;
    host_wr(2'd0, 8'hC7);
    for (int i = 0; i < 18; i++) send_slot("R3 D4 tx bit");

    // R5/R11 ESF receive, raw run of ones
    do_reset();
    d4 = 1'b0;
    recv_byte(8'h1F, 1'b0);
    host_rd("R11 raw byte", 2'd1);
    chk("R5 full set", int'(m_full), 1);
    chk("R9 masked irq high", int'(irq_n), 1);
    host_wr(2'd3, 8'h01);
    chk("R9 unmasked irq low", int'(irq_n), 0);
    host_rd("R5 status full", 2'd2);
    chk("R8 read cleared irq", int'(irq_n), 1);
    host_rd("R8 status after read", 2'd2);

    // R8 write-one-to-clear
    recv_byte(8'h96, 1'b0);
    host_wr(2'd2, 8'h00);
    host_rd("R8 write 0 keeps", 2'd2);
    recv_byte(8'h69, 1'b0);
    host_wr(2'd2, 8'h01);
    chk("R8 w1c irq", int'(irq_n), 1);
    host_rd("R8 after w1c", 2'd2);

    // R10 overwrite
    recv_byte(8'h12, 1'b0);
    recv_byte(8'hE4, 1'b0);
    host_rd("R10 second byte kept", 2'd1);
    chk("R10 full still set", int'(irq_n), 0);
    host_wr(2'd3, 8'h00);
    chk("R9 mask off irq high", int'(irq_n), 1);

    // R7 sync realign
    host_rd("R8 clear", 2'd2);
    recv_slot(1'b1, 1'b0);
    recv_slot(1'b1, 1'b0);
    recv_slot(1'b1, 1'b0);
    recv_byte(8'h5A, 1'b1);
    host_rd("R7 realigned byte", 2'd1);

    // R6 D4 receive
    do_reset();
    d4 = 1'b1;
    recv_byte(8'hFF, 1'b1);
    host_rd("R6 D4 byte upper zero", 2'd1);
    host_rd("R6 D4 full", 2'd2);
    recv_byte(8'h2A, 1'b0);
    host_rd("R6 D4 second byte", 2'd1);

    random_phase(1'b0, 600);
    random_phase(1'b1, 600);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule